// File: doc/BRIEF.md
# Display Attribute Timing Generator

This block produces the per-digit visibility mask and a brightness gate for an eight-digit dot-matrix LED display. A free-running timebase divides the clock by 28,672 to make a common on/off rhythm. That rhythm is applied either to every digit, when the global blink mode is on, or only to the digits whose attribute bit is set, when per-digit flashing is on and global blink is off. Global blink always takes precedence over per-digit flashing.

Brightness is set by a 3-bit code and realised as a 15-slot pulse-width frame. The gate is high for the first N slots of each frame, where N follows a fixed non-linear table that runs from fully on down to fully blank. The code is captured only at frame boundaries, so a new code never produces a partial frame. A synchronous reset restarts both counters, so several instances on one clock stay in phase.

Top module: `disp_attr_timer`

## Requirements
- R1: Brightness code 3'b000 keeps `pwm_gate` high in all 15 slots of a frame.
- R2: Brightness code 3'b111 keeps `pwm_gate` low in every slot.
- R3: Codes 3'b001 through 3'b110 drive `pwm_gate` high for the first 12, 8, 6, 4, 3 and 2 slots of the 15-slot frame, in that order, and low for the rest.
- R4: A frame uses the code present on `bright_code` in the clock cycle before the frame's first slot. A code change in any other cycle has no effect until the next frame starts.
- R5: The blink phase has a period of 28,672 clocks. It is visible for the first 14,336 cycles after reset, or after each wrap, and hidden for the remaining 14,336.
- R6: With `blink_en`=1, every bit of `digit_vis` equals the blink phase.
- R7: With `blink_en`=0 and `flash_en`=1, `digit_vis[i]` follows the blink phase where `flash_attr[i]`=1. It is 1 where `flash_attr[i]`=0. Bit i is digit i.
- R8: With `blink_en`=0 and `flash_en`=0, `digit_vis` is all ones whatever `flash_attr` holds.
- R9: With both `blink_en`=1 and `flash_en`=1, digits whose attribute bit is 0 still blink, because blink overrides flash.
- R10: While `rst` is high and in the first cycle after it falls, the blink phase is visible and the frame is at slot 0. The first frame uses the code present during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bright_code | input | 3 | Brightness code; 000 brightest, 111 blank |
| flash_en | input | 1 | Enables per-digit flashing from `flash_attr` |
| blink_en | input | 1 | Blinks all digits together; overrides flashing |
| flash_attr | input | 8 | One flash attribute bit per digit |
| digit_vis | output | 8 | One visibility bit per digit, 1 = lit |
| pwm_gate | output | 1 | Brightness gate for the current PWM slot |

## Verification
Two functions can land in the same clock: the PWM frame boundary that captures a new brightness code, and a change of the blink or flash mode that alters `digit_vis`. The bench drives a new code and a new mode together in exactly the last slot of a frame. It also drives a decoy code one slot earlier. A behavioural model that tracks slot and phase as integers judges both outputs in every cycle: the gate must follow the boundary code from the next cycle, and the mask must follow the mode at once. A mid-run reset and a run across the half-period and the full-period points check the phase count.

// File: rtl/disp_attr_pkg.sv
package disp_attr_pkg;

    localparam int CODE_W    = 3;
    localparam int PWM_SLOTS = 15;
    localparam int SLOT_W    = $clog2(PWM_SLOTS);

    typedef logic [CODE_W-1:0] bright_code_t;
    typedef logic [SLOT_W-1:0] slot_t;

    // On-slot count per brightness code; non-linear, ends fully blank.
    function automatic slot_t on_slots(input bright_code_t code);
        slot_t n;
        case (code)
            3'd0:    n = slot_t'(15);
            3'd1:    n = slot_t'(12);
            3'd2:    n = slot_t'(8);
            3'd3:    n = slot_t'(6);
            3'd4:    n = slot_t'(4);
            3'd5:    n = slot_t'(3);
            3'd6:    n = slot_t'(2);
            default: n = slot_t'(0);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/dat_blink_timebase.sv
module dat_blink_timebase #(
    parameter int BLINK_DIV = 28672
) (
    input  logic clk,
    input  logic rst,
    output logic phase_vis
);
    localparam int CNT_W = $clog2(BLINK_DIV);
    localparam int HALF  = BLINK_DIV / 2;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BLINK_DIV - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tb_state_t;

    tb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST_CNT) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (rst) begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign phase_vis = (st_q.cnt < CNT_W'(HALF));

endmodule

// File: rtl/dat_pwm_frame.sv
module dat_pwm_frame
    import disp_attr_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  bright_code_t bright_code,
    output logic         gate,
    output slot_t        slot_o,
    output bright_code_t code_o
);
    localparam slot_t LAST_SLOT = slot_t'(PWM_SLOTS - 1);

    typedef struct packed {
        slot_t        slot;
        bright_code_t code;
    } pwm_state_t;

    pwm_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.slot == LAST_SLOT) begin
            st_d.slot = '0;
            st_d.code = bright_code;     // capture only at frame boundary
        end else begin
            st_d.slot = st_q.slot + 1'b1;
        end
        if (rst) begin
            st_d.slot = '0;
            st_d.code = bright_code;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign gate   = (st_q.slot < on_slots(st_q.code));
    assign slot_o = st_q.slot;
    assign code_o = st_q.code;

endmodule

// File: rtl/dat_digit_mask.sv
module dat_digit_mask #(
    parameter int NUM_DIGITS = 8
) (
    input  logic                  phase_vis,
    input  logic                  blink_en,
    input  logic                  flash_en,
    input  logic [NUM_DIGITS-1:0] flash_attr,
    output logic [NUM_DIGITS-1:0] digit_vis
);
    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
        logic blinking;
        // Global blink wins; otherwise the attribute gates flashing.
        assign blinking     = blink_en | (flash_en & flash_attr[g]);
        assign digit_vis[g] = phase_vis | ~blinking;
    end

endmodule

// File: rtl/disp_attr_timer.sv
module disp_attr_timer
    import disp_attr_pkg::*;
#(
    parameter int NUM_DIGITS = 8,
    parameter int BLINK_DIV  = 28672
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [CODE_W-1:0]     bright_code,
    input  logic                  flash_en,
    input  logic                  blink_en,
    input  logic [NUM_DIGITS-1:0] flash_attr,
    output logic [NUM_DIGITS-1:0] digit_vis,
    output logic                  pwm_gate
);
    logic         blink_phase;
    slot_t        pwm_slot;
    bright_code_t pwm_code;

    dat_blink_timebase #(.BLINK_DIV(BLINK_DIV)) u_timebase (
        .clk       (clk),
        .rst       (rst),
        .phase_vis (blink_phase)
    );

    dat_pwm_frame u_pwm (
        .clk         (clk),
        .rst         (rst),
        .bright_code (bright_code),
        .gate        (pwm_gate),
        .slot_o      (pwm_slot),
        .code_o      (pwm_code)
    );

    dat_digit_mask #(.NUM_DIGITS(NUM_DIGITS)) u_mask (
        .phase_vis  (blink_phase),
        .blink_en   (blink_en),
        .flash_en   (flash_en),
        .flash_attr (flash_attr),
        .digit_vis  (digit_vis)
    );

endmodule

// File: rtl/dat_checker.sv
module dat_checker
    import disp_attr_pkg::*;
#(
    parameter int NUM_DIGITS = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  blink_en,
    input  logic                  flash_en,
    input  logic [NUM_DIGITS-1:0] flash_attr,
    input  logic [NUM_DIGITS-1:0] digit_vis,
    input  logic                  pwm_gate,
    input  logic                  blink_phase,
    input  slot_t                 pwm_slot,
    input  bright_code_t          pwm_code
);
    localparam slot_t LAST_SLOT = slot_t'(PWM_SLOTS - 1);

    assert_full_on_R1: assert property (@(posedge clk) disable iff (rst)
        (pwm_code == 3'd0) |-> pwm_gate);

    assert_blank_R2: assert property (@(posedge clk) disable iff (rst)
        (pwm_code == 3'd7) |-> !pwm_gate);

    assert_slot_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (pwm_slot == LAST_SLOT) |=> (pwm_slot == '0));

    assert_code_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (pwm_slot != '0) |-> $stable(pwm_code));

    assert_blink_all_R6: assert property (@(posedge clk) disable iff (rst)
        (blink_en && !blink_phase) |-> (digit_vis == '0));

    assert_flash_attr_R7: assert property (@(posedge clk) disable iff (rst)
        (!blink_en && flash_en) |-> ((digit_vis | flash_attr) == '1));

    assert_no_attr_R8: assert property (@(posedge clk) disable iff (rst)
        (!blink_en && !flash_en) |-> (&digit_vis));

    assert_reset_phase_R10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (blink_phase && pwm_slot == '0));

endmodule

bind disp_attr_timer dat_checker #(.NUM_DIGITS(NUM_DIGITS)) u_dat_checker (
    .clk         (clk),
    .rst         (rst),
    .blink_en    (blink_en),
    .flash_en    (flash_en),
    .flash_attr  (flash_attr),
    .digit_vis   (digit_vis),
    .pwm_gate    (pwm_gate),
    .blink_phase (blink_phase),
    .pwm_slot    (pwm_slot),
    .pwm_code    (pwm_code)
);

// File: tb/tb_disp_attr_timer.sv
module tb_disp_attr_timer;

    localparam int PERIOD = 28672;
    localparam int HALF   = PERIOD / 2;
    localparam int SLOTS  = 15;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bright_code = 3'd0;
    logic       flash_en = 1'b0;
    logic       blink_en = 1'b0;
    logic [7:0] flash_attr = 8'h00;
    logic [7:0] digit_vis;
    logic       pwm_gate;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference model state
    int  m_cnt  = 0;
    int  m_slot = 0;
    int  m_code = 0;
    bit  m_valid = 1'b0;
    int  on_tbl [8] = '{15, 12, 8, 6, 4, 3, 2, 0};

    always #10 clk = ~clk;   // 50 MHz

    disp_attr_timer dut (
        .clk         (clk),
        .rst         (rst),
        .bright_code (bright_code),
        .flash_en    (flash_en),
        .blink_en    (blink_en),
        .flash_attr  (flash_attr),
        .digit_vis   (digit_vis),
        .pwm_gate    (pwm_gate)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_cnt  = 0;
            m_slot = 0;
            m_code = int'(bright_code);
        end else begin
            m_cnt = (m_cnt + 1) % PERIOD;
            if (m_slot == SLOTS - 1) begin
                m_slot = 0;
                m_code = int'(bright_code);
            end else begin
                m_slot = m_slot + 1;
            end
        end
        m_valid = 1'b1;
    end

    function automatic bit exp_phase();
        return (m_cnt < HALF);
    endfunction

    function automatic logic [7:0] exp_vis();
        logic [7:0] v;
        for (int i = 0; i < 8; i++)
            v[i] = exp_phase() | ~(blink_en | (flash_en & flash_attr[i]));
        return v;
    endfunction

    task automatic report(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare both outputs with the model in the current cycle.
    task automatic compare_now();
        string rg, rv;
        if (!m_valid) return;
        if (m_code != int'(bright_code) && m_slot != 0) rg = "R4";
        else if (m_code == 0) rg = "R1";
        else if (m_code == 7) rg = "R2";
        else rg = "R3";
        report(rg, "pwm_gate", int'(pwm_gate), int'(m_slot < on_tbl[m_code]));
        if (blink_en && flash_en && flash_attr != 8'hFF) rv = "R9";
        else if (blink_en) rv = "R6";
        else if (flash_en) rv = "R7";
        else rv = "R8";
        report(rv, "digit_vis", int'(digit_vis), int'(exp_vis()));
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            compare_now();
        end
    endtask

    task automatic do_reset(input int n);
        @(negedge clk);
        rst = 1'b1;
        step(n);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        // Reset state (R10)
        bright_code = 3'd0;
        step(4);
        report("R10", "reset gate", int'(pwm_gate), 1);
        report("R10", "reset vis", int'(digit_vis), 8'hFF);
        @(negedge clk);
        rst = 1'b0;
        step(1);
        report("R10", "first slot gate", int'(pwm_gate), 1);

        // Codes at unaligned times, no blink/flash (R1..R4, R8)
        flash_attr = 8'hA5;
        for (int c = 0; c < 24; c++) begin
            bright_code = 3'(c % 8);
            step(37);
        end
        for (int c = 0; c < 8; c++) begin
            bright_code = 3'(c);
            step(3 * SLOTS);
        end

        // Global blink with flash also on, crossing the half period (R5, R6, R9)
        blink_en = 1'b1;
        flash_en = 1'b1;
        flash_attr = 8'h0F;
        bright_code = 3'd2;
        while (m_cnt != HALF - 2) step(1);
        step(1);
        report("R5", "last visible", int'(digit_vis), 8'hFF);
        step(1);
        report("R9", "hidden despite attr", int'(digit_vis), 8'h00);
        step(2000);

        // Flash only, crossing the wrap (R5, R7)
        blink_en = 1'b0;
        flash_attr = 8'h3C;
        while (m_cnt != PERIOD - 2) step(1);
        step(1);
        report("R7", "flash hidden", int'(digit_vis), 8'hC3);
        step(1);
        report("R5", "wrap visible", int'(digit_vis), 8'hFF);
        step(500);

        // Flash disabled, attributes ignored (R8)
        flash_en = 1'b0;
        flash_attr = 8'hFF;
        while (m_cnt != HALF + 10) step(1);
        report("R8", "attr ignored", int'(digit_vis), 8'hFF);
        step(300);

        // Mid-run reset restarts the phase (R10, R5)
        blink_en = 1'b1;
        bright_code = 3'd5;
        do_reset(3);
        step(1);
        report("R10", "post-reset vis", int'(digit_vis), 8'hFF);
        while (m_cnt != HALF - 1) step(1);
        report("R5", "still visible", int'(digit_vis), 8'hFF);
        step(1);
        report("R5", "now hidden", int'(digit_vis), 8'h00);

        // Coincidence: decoy code one slot early, then code plus mode in last slot (R4)
        for (int r = 0; r < 8; r++) begin
            while (m_slot != SLOTS - 2) step(1);
            bright_code = 3'(7 - r);
            step(1);
            bright_code = 3'(r);
            blink_en = r[0];
            flash_en = r[1];
            flash_attr = 8'(8'h11 << r);
            step(1);
            report("R4", "boundary gate", int'(pwm_gate), int'(on_tbl[r] > 0));
            step(SLOTS + 3);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule